// File: doc/BRIEF.md
# Serial Register Write Port

This block is a slave control port on four serial pins: an active-low chip select, a serial clock, a data input and a data output with a separate output enable. A host lowers chip select and shifts in, most significant bit first, a 7-bit device address, a read/write flag, a pointer byte and then data bytes. When the address matches, each data byte is stored in an internal bank of 8-bit setting registers. The bank is presented in parallel on `regs_o` to drive the rest of the chip.

The pointer byte has two parts. Its top bit enables automatic increment. Its low seven bits select a register. The pointer keeps its value between transactions. A later read transaction therefore streams out the registers from the point where the last write left the pointer. The block runs only on the serial clock and chip select, plus an asynchronous reset. Raising chip select ends a transaction at any point.

Top module: `spi_reg_slave`

## Requirements
- R1: While `rst_ni` is low, every register reads 0 on `regs_o` and `sdo_oe_o` is 0.
- R2: `sdi_i` is sampled on rising `sclk_i`, MSB first. A data byte reaches its register at the rising edge that carries the byte's last bit, and not before.
- R3: If the first 7 bits after chip select falls differ from `DEV_ADDR` (default 7'b0010000), the rest of the transaction changes no register and `sdo_oe_o` stays 0.
- R4: The 8th bit selects the direction: 0 means write and 1 means read. A read changes no register.
- R5: In a write, the byte after the address byte loads the pointer. Its bit 7 is the increment enable and bits 6:0 are the register address. With the enable at 0, every data byte goes to the same register, and the last byte wins.
- R6: With the enable at 1, successive data bytes go to successive addresses. The address wraps from 127 to 0.
- R7: `sdo_oe_o` is 0 throughout a write transaction and whenever `cs_ni` is high.
- R8: Raising `cs_ni` discards a partial byte. The next transaction starts again with the address byte, and the pointer keeps its last complete value.
- R9: In a read, the first falling `sclk_i` edge after the address byte sets `sdo_oe_o` to 1. `sdo_o` then presents the register at the pointer, MSB first, and changes on falling edges.
- R10: In a read with the enable at 1, the pointer advances after each byte. With the enable at 0, the same register repeats.
- R11: Addresses at or above `NUM_REGS` are not stored. A write to such an address is dropped and a read from it returns 0.
- R12: The pointer persists across transactions, including ignored ones, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial bit clock from the host |
| sdi_i | input | 1 | Serial data from the host |
| sdo_o | output | 1 | Serial data to the host |
| sdo_oe_o | output | 1 | Enable for the data output driver; 0 means high impedance |
| regs_o | output | NUM_REGS*8 | Register bank, with register i at bits [8i+7:8i] |

## Verification
The bench builds the block with `NUM_REGS` set to 12 and the default device address. This makes addresses 12 to 127 unbacked, so a short burst can cross the end of the bank and a burst starting at 127 can wrap to address 0. With these settings, the dropped writes, the zero reads and the wraparound of the 7-bit pointer are all reached within a few transactions.

// File: rtl/spi_reg_slave_pkg.sv
package spi_reg_slave_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PTR_W  = 7;

  typedef enum logic [2:0] {
    PH_DEV,
    PH_PTR,
    PH_DATA,
    PH_READ,
    PH_SKIP
  } phase_e;
endpackage

// File: rtl/spi_rx_shift.sv
module spi_rx_shift
  import spi_reg_slave_pkg::*;
(
  input  logic              sclk_i,
  input  logic              sess_rst_ni,
  input  logic              sdi_i,
  output logic [2:0]        bit_cnt_o,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_done_o
);
  logic [BYTE_W-2:0] sh_q;
  logic [2:0]        cnt_q;

  always_ff @(posedge sclk_i or negedge sess_rst_ni) begin
    if (!sess_rst_ni) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= {sh_q[BYTE_W-3:0], sdi_i};
      cnt_q <= cnt_q + 3'd1;
    end
  end

  // byte completes combinationally on the edge carrying its last bit
  assign byte_o      = {sh_q, sdi_i};
  assign byte_done_o = (cnt_q == 3'd7);
  assign bit_cnt_o   = cnt_q;
endmodule

// File: rtl/spi_seq.sv
module spi_seq
  import spi_reg_slave_pkg::*;
#(
  parameter logic [PTR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic              sclk_i,
  input  logic              rst_ni,
  input  logic              sess_rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              byte_done_i,
  output phase_e            phase_o,
  output logic [PTR_W-1:0]  ptr_o,
  output logic              incr_o,
  output logic              we_o,
  output logic [BYTE_W-1:0] wdata_o
);
  phase_e           phase_q, phase_d;
  logic [PTR_W-1:0] ptr_q;
  logic             incr_q;

  always_comb begin
    phase_d = phase_q;
    if (byte_done_i) begin
      unique case (phase_q)
        PH_DEV: begin
          if (byte_i[BYTE_W-1:1] != DEV_ADDR) phase_d = PH_SKIP;
          else if (byte_i[0])                 phase_d = PH_READ;
          else                                phase_d = PH_PTR;
        end
        PH_PTR:  phase_d = PH_DATA;
        default: phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge sclk_i or negedge sess_rst_ni) begin
    if (!sess_rst_ni) phase_q <= PH_DEV;
    else              phase_q <= phase_d;
  end

  // pointer survives chip-select cycles
  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q  <= '0;
      incr_q <= 1'b0;
    end else if (byte_done_i && phase_q == PH_PTR) begin
      ptr_q  <= byte_i[PTR_W-1:0];
      incr_q <= byte_i[BYTE_W-1];
    end else if (byte_done_i && incr_q &&
                 (phase_q == PH_DATA || phase_q == PH_READ)) begin
      ptr_q  <= ptr_q + 7'd1;
    end
  end

  assign we_o    = byte_done_i && (phase_q == PH_DATA);
  assign wdata_o = byte_i;
  assign phase_o = phase_q;
  assign ptr_o   = ptr_q;
  assign incr_o  = incr_q;
endmodule

// File: rtl/spi_regfile.sv
module spi_regfile
  import spi_reg_slave_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input  logic                       sclk_i,
  input  logic                       rst_ni,
  input  logic                       we_i,
  input  logic [PTR_W-1:0]           waddr_i,
  input  logic [BYTE_W-1:0]          wdata_i,
  input  logic [PTR_W-1:0]           raddr_i,
  output logic [BYTE_W-1:0]          rdata_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic [BYTE_W-1:0] mem_q [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge sclk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[g] <= '0;
      else if (we_i && waddr_i == PTR_W'(g))   mem_q[g] <= wdata_i;
    end
    assign regs_o[g*BYTE_W +: BYTE_W] = mem_q[g];
  end

  // unbacked addresses read as zero
  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (raddr_i == PTR_W'(i)) rdata_o = mem_q[i];
    end
  end
endmodule

// File: rtl/spi_tx.sv
module spi_tx
  import spi_reg_slave_pkg::*;
(
  input  logic              sclk_i,
  input  logic              sess_rst_ni,
  input  logic              rd_active_i,
  input  logic [2:0]        bit_cnt_i,
  input  logic [BYTE_W-1:0] rdata_i,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  always_ff @(negedge sclk_i or negedge sess_rst_ni) begin
    if (!sess_rst_ni) begin
      sdo_o    <= 1'b0;
      sdo_oe_o <= 1'b0;
    end else begin
      sdo_oe_o <= rd_active_i;
      sdo_o    <= rd_active_i ? rdata_i[3'd7 - bit_cnt_i] : 1'b0;
    end
  end
endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
  import spi_reg_slave_pkg::*;
#(
  parameter int unsigned      NUM_REGS = 16,
  parameter logic [PTR_W-1:0] DEV_ADDR = 7'b0010000
) (
  input  logic                       rst_ni,
  input  logic                       cs_ni,
  input  logic                       sclk_i,
  input  logic                       sdi_i,
  output logic                       sdo_o,
  output logic                       sdo_oe_o,
  output logic [NUM_REGS*BYTE_W-1:0] regs_o
);
  logic              sess_rst_n;
  logic [2:0]        bit_cnt;
  logic [BYTE_W-1:0] rx_byte;
  logic              byte_done;
  phase_e            phase;
  logic [PTR_W-1:0]  ptr;
  logic              incr;
  logic              we;
  logic [BYTE_W-1:0] wdata;
  logic [BYTE_W-1:0] rdata;

  assign sess_rst_n = rst_ni & ~cs_ni;

  spi_rx_shift u_rx (
    .sclk_i      (sclk_i),
    .sess_rst_ni (sess_rst_n),
    .sdi_i       (sdi_i),
    .bit_cnt_o   (bit_cnt),
    .byte_o      (rx_byte),
    .byte_done_o (byte_done)
  );

  spi_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
    .sclk_i      (sclk_i),
    .rst_ni      (rst_ni),
    .sess_rst_ni (sess_rst_n),
    .byte_i      (rx_byte),
    .byte_done_i (byte_done),
    .phase_o     (phase),
    .ptr_o       (ptr),
    .incr_o      (incr),
    .we_o        (we),
    .wdata_o     (wdata)
  );

  spi_regfile #(.NUM_REGS(NUM_REGS)) u_rf (
    .sclk_i  (sclk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (ptr),
    .wdata_i (wdata),
    .raddr_i (ptr),
    .rdata_o (rdata),
    .regs_o  (regs_o)
  );

  spi_tx u_tx (
    .sclk_i      (sclk_i),
    .sess_rst_ni (sess_rst_n),
    .rd_active_i (phase == PH_READ),
    .bit_cnt_i   (bit_cnt),
    .rdata_i     (rdata),
    .sdo_o       (sdo_o),
    .sdo_oe_o    (sdo_oe_o)
  );
endmodule

// File: rtl/spi_reg_slave_chk.sv
module spi_reg_slave_chk
  import spi_reg_slave_pkg::*;
#(
  parameter int unsigned NUM_REGS = 16
) (
  input logic                       sclk_i,
  input logic                       rst_ni,
  input logic                       cs_ni,
  input logic                       sdo_oe_o,
  input logic [NUM_REGS*BYTE_W-1:0] regs_o,
  input phase_e                     phase,
  input logic [PTR_W-1:0]           ptr,
  input logic                       incr,
  input logic                       we,
  input logic [2:0]                 bit_cnt
);
  AST_WRITE_NO_OE: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_PTR || phase == PH_DATA) |-> !sdo_oe_o); // R7

  AST_SKIP_HOLDS_REGS: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_SKIP) |=> $stable(regs_o)); // R3

  AST_PTR_HELD: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (we && !incr) |=> (ptr == $past(ptr))); // R5

  AST_PTR_STEP: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (we && incr) |=> (ptr == PTR_W'($past(ptr) + 7'd1))); // R6

  AST_OOR_DROP: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (we && (int'(ptr) >= NUM_REGS)) |=> $stable(regs_o)); // R11

  AST_READ_DRIVES: assert property (@(posedge sclk_i) disable iff (!rst_ni || cs_ni)
    (phase == PH_READ && bit_cnt != 3'd0) |-> sdo_oe_o); // R9
endmodule

bind spi_reg_slave spi_reg_slave_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .sclk_i   (sclk_i),
  .rst_ni   (rst_ni),
  .cs_ni    (cs_ni),
  .sdo_oe_o (sdo_oe_o),
  .regs_o   (regs_o),
  .phase    (phase),
  .ptr      (ptr),
  .incr     (incr),
  .we       (we),
  .bit_cnt  (bit_cnt)
);

// File: tb/tb_spi_reg_slave.sv
module tb_spi_reg_slave;
  localparam int unsigned NR  = 12;
  localparam logic [6:0]  DEV = 7'b0010000;

  logic clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  logic rst_ni, cs_ni, sclk, sdi, sdo, sdo_oe;
  logic [NR*8-1:0] regs;

  spi_reg_slave #(.NUM_REGS(NR), .DEV_ADDR(DEV)) dut (
    .rst_ni   (rst_ni),
    .cs_ni    (cs_ni),
    .sclk_i   (sclk),
    .sdi_i    (sdi),
    .sdo_o    (sdo),
    .sdo_oe_o (sdo_oe),
    .regs_o   (regs)
  );

  int checks = 0;
  int failures = 0;
  logic [7:0] model [NR];
  logic [6:0] mptr = '0;
  logic       mincr = 1'b0;
  logic       in_write = 1'b0;
  int         oe_viol = 0;

  // {ptr byte, data0, data1, count}
  localparam logic [31:0] VEC [6] = '{
    32'h01_A5_00_01, 32'h02_3C_00_01, 32'h84_11_22_02,
    32'h07_55_66_02, 32'h8A_77_88_02, 32'h00_FF_00_01
  };

  always @(posedge sclk) if (in_write && sdo_oe) oe_viol++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_regs(input string req);
    int bad = -1;
    for (int i = 0; i < int'(NR); i++)
      if (bad < 0 && regs[i*8 +: 8] !== model[i]) bad = i;
    if (bad < 0) chk(1'b1, req, 0, 0);
    else chk(1'b0, req, int'(regs[bad*8 +: 8]), int'(model[bad]));
  endtask

  task automatic put_bit(input logic b);
    sdi = b; #10 sclk = 1'b1; #10 sclk = 1'b0;
  endtask

  task automatic put_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
  endtask

  task automatic begin_txn();
    cs_ni = 1'b0; #10;
  endtask

  task automatic end_txn();
    #10 cs_ni = 1'b1; #20;
  endtask

  task automatic model_wr(input logic [7:0] d);
    if (int'(mptr) < int'(NR)) model[mptr] = d;
    if (mincr) mptr = mptr + 7'd1;
  endtask

  task automatic wr_txn(input logic [6:0] dev, input logic [7:0] pb,
                        input int n, input logic [15:0] d);
    in_write = 1'b1;
    begin_txn();
    put_byte({dev, 1'b0});
    put_byte(pb);
    for (int k = 0; k < n; k++) put_byte(k == 0 ? d[15:8] : d[7:0]);
    end_txn();
    in_write = 1'b0;
    if (dev == DEV) begin
      mptr = pb[6:0]; mincr = pb[7];
      for (int k = 0; k < n; k++) model_wr(k == 0 ? d[15:8] : d[7:0]);
    end
  endtask

  task automatic rd_txn(input int n);
    logic [7:0] got, exp;
    begin_txn();
    for (int i = 7; i >= 1; i--) put_bit(DEV[i-1]);
    sdi = 1'b1; #10 sclk = 1'b1; #5;
    chk(sdo_oe === 1'b0, "R9 oe before first falling edge", int'(sdo_oe), 0);
    #5 sclk = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int i = 7; i >= 0; i--) begin
        sdi = 1'b0; #9;
        if (i == 7) chk(sdo_oe === 1'b1, "R9 oe during read", int'(sdo_oe), 1);
        got[i] = sdo;
        #1 sclk = 1'b1; #10 sclk = 1'b0;
      end
      exp = (int'(mptr) < int'(NR)) ? model[mptr] : 8'h00;
      chk(got === exp, "R9/R10/R11 read byte", int'(got), int'(exp));
      if (mincr) mptr = mptr + 7'd1;
    end
    end_txn();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < int'(NR); i++) model[i] = 8'h00;
    rst_ni = 1'b0; cs_ni = 1'b1; sclk = 1'b0; sdi = 1'b0;
    #15;
    check_regs("R1 regs zero in reset");
    chk(sdo_oe === 1'b0, "R1 oe low in reset", int'(sdo_oe), 0);
    #20 rst_ni = 1'b1; #20;

    // vector table: R2 R5 R6
    foreach (VEC[v]) begin
      wr_txn(DEV, VEC[v][31:24], int'(VEC[v][7:0]), VEC[v][23:8]);
      check_regs("R2/R5/R6 table write");
    end
    chk(oe_viol == 0, "R7 oe low in writes", oe_viol, 0);

    // R3 wrong device address
    wr_txn(7'h11, 8'h03, 1, 16'h9900);
    check_regs("R3 mismatched address ignored");
    chk(sdo_oe === 1'b0, "R3 oe idle", int'(sdo_oe), 0);

    // R12 pointer from last write (0x00, no incr) survives the ignored txn
    rd_txn(1);

    // R8 abort inside data byte
    in_write = 1'b1;
    begin_txn();
    put_byte({DEV, 1'b0});
    put_byte(8'h02);
    for (int i = 7; i >= 3; i--) put_bit(1'b1);
    end_txn();
    in_write = 1'b0;
    mptr = 7'h02; mincr = 1'b0;
    check_regs("R8 partial byte discarded");
    rd_txn(1); // R8 R12 pointer kept, fresh address phase
    check_regs("R4 read leaves registers");

    // R10 incr read burst and repeat read
    wr_txn(DEV, 8'h84, 0, 16'h0);
    rd_txn(3);
    wr_txn(DEV, 8'h07, 0, 16'h0);
    rd_txn(2);

    // R11 out of range
    wr_txn(DEV, 8'h0C, 1, 16'hAB00);
    check_regs("R11 write above bank dropped");
    wr_txn(DEV, 8'h8B, 2, 16'hC3D4);
    check_regs("R11 burst crosses end");
    wr_txn(DEV, 8'h0D, 0, 16'h0);
    rd_txn(1);

    // R6 wrap 127 -> 0
    wr_txn(DEV, 8'hFF, 2, 16'h1E2F);
    check_regs("R6 pointer wraps to 0");
    chk(oe_viol == 0, "R7 oe low in writes", oe_viol, 0);

    // R2 commit on the rising edge of the last bit
    begin_txn();
    put_byte({DEV, 1'b0});
    put_byte(8'h09);
    for (int i = 7; i >= 1; i--) put_bit(1'b1);
    sdi = 1'b0; #5;
    chk(regs[9*8 +: 8] === model[9], "R2 not yet written", int'(regs[9*8 +: 8]), int'(model[9]));
    #5 sclk = 1'b1; #5;
    chk(regs[9*8 +: 8] === 8'hFE, "R2 written at last rising edge", int'(regs[9*8 +: 8]), 'hFE);
    #5 sclk = 1'b0;
    end_txn();
    model[9] = 8'hFE; mptr = 7'h09; mincr = 1'b0;
    check_regs("R2 final state");

    // R1 reset clears bank
    rst_ni = 1'b0; #15;
    for (int i = 0; i < int'(NR); i++) model[i] = 8'h00;
    check_regs("R1 reset clears bank");
    rst_ni = 1'b1; #20;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule